// File: doc/BRIEF.md
# Sixteen-Pin GPIO Expander Core with Interrupt-on-Change

This block is the register and pin core of a port expander. It has sixteen general-purpose pins in two banks of eight. Each bank holds its own direction, input inversion, interrupt enable, reference value, compare-mode, pull-up and output latch registers, plus a flag register and a capture register. A single configuration register is shared by both banks. A host-side controller, such as a serial bus slave that is not part of this block, reaches the registers through a plain synchronous port. That port has a write strobe and a read strobe, and read data arrives one cycle after the read strobe. The pin inputs are assumed to be synchronised already.

Each bank raises an interrupt when one of its enabled input pins changes, or when the pin differs from its reference bit. The bank then latches the identity of the first causing pin and a snapshot of the bank's pins. The interrupt stays pending until the host reads the bank's port register, or its capture register when the configuration selects that. The two interrupt outputs can be merged, inverted in polarity, or driven as open-drain.

Top module: `gpx_core`

## Requirements
- R1: After reset every pin is an input (pin_oe all zero), and pin_out and pull_en are zero. Direction registers read 0xFF, every other register reads 0x00, and both interrupt outputs sit deasserted: irq_out = 2'b11 and irq_oe = 2'b11.
- R2: reg_addr[4] selects the bank (0 for pins 7..0, 1 for pins 15..8) and reg_addr[3:0] selects the register: 0 direction, 1 inversion, 2 interrupt enable, 3 reference, 4 compare mode, 5 configuration, 6 pull-up, 7 flag, 8 capture, 9 port, 10 output latch. A write takes effect at its clock edge. reg_rdata holds the value read at the edge that samples reg_rd. The configuration register is the same for both banks. Indices 11 to 15 read 0x00.
- R3: pin_oe is the inverse of the direction bits, pin_out is the output latch, and pull_en is the pull-up register.
- R4: A port read returns the pin value XOR the inversion bits.
- R5: With a compare-mode bit of 0, an enabled pin whose direction bit is 1 sets a flag in the same edge where its value differs from the value at the previous edge. Pins set as outputs never flag.
- R6: With a compare-mode bit of 1, an enabled input pin flags whenever it differs from its reference bit, and it flags again after a clear while the mismatch persists.
- R7: Within a bank only one flag bit is set: the lowest-numbered causing pin. The two banks flag independently.
- R8: When a bank flags, its capture register loads that bank's pins XOR inversion. The other bank's capture is left alone. While a flag is pending, that bank's flag and capture do not change.
- R9: With configuration bit 0 clear, a port read clears that bank's flag. With the bit set, a capture read clears it and a port read does not.
- R10: Configuration bit 6 makes both outputs follow the OR of the two banks, bit 1 makes the asserted level high (otherwise low), and bit 2 makes irq_oe high only while asserted (otherwise always high).
- R11: Writes to the flag, capture and port indices change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 5 | Bank select and register index |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe (triggers clear side effects) |
| reg_rdata | output | 8 | Registered read data |
| pin_in | input | 16 | Synchronised pin levels |
| pin_out | output | 16 | Pin output levels |
| pin_oe | output | 16 | Pin output enables |
| pull_en | output | 16 | Pull-up enables |
| irq_out | output | 2 | Interrupt output levels, one per bank |
| irq_oe | output | 2 | Interrupt output enables |

## Verification
A pin change that the bench drives at a falling edge is seen at the next rising edge. The flag, the capture and the interrupt outputs are therefore checked one nanosecond after that rising edge, with no added delay. A read strobe drives reg_rdata at the rising edge where it is sampled, and that same edge applies any clear. The bench reads just after that edge. It checks the cleared flag with a later read, a full cycle on. In compare mode, re-flagging takes one more edge after the clear, and the next read falls after that edge.

// File: rtl/gpx_pkg.sv
package gpx_pkg;

    localparam int IDX_W = 4;

    typedef enum logic [IDX_W-1:0] {
        IX_DIR  = 4'h0,
        IX_INV  = 4'h1,
        IX_IEN  = 4'h2,
        IX_REF  = 4'h3,
        IX_MODE = 4'h4,
        IX_CFG  = 4'h5,
        IX_PULL = 4'h6,
        IX_FLAG = 4'h7,
        IX_CAPT = 4'h8,
        IX_PORT = 4'h9,
        IX_LAT  = 4'hA
    } reg_idx_e;

    localparam int CFG_CLR_ON_CAP = 0;
    localparam int CFG_ACT_HIGH   = 1;
    localparam int CFG_OPEN_DRAIN = 2;
    localparam int CFG_MIRROR     = 6;

    typedef struct packed {
        logic mirror;
        logic open_drain;
        logic act_high;
        logic clr_on_cap;
    } irq_cfg_t;

    typedef struct packed {
        logic oe;
        logic level;
    } irq_pin_t;

    function automatic irq_cfg_t decode_cfg(input logic [7:0] c);
        irq_cfg_t r;
        r.mirror     = c[CFG_MIRROR];
        r.open_drain = c[CFG_OPEN_DRAIN];
        r.act_high   = c[CFG_ACT_HIGH];
        r.clr_on_cap = c[CFG_CLR_ON_CAP];
        return r;
    endfunction

    function automatic irq_pin_t drive_irq(input logic asserted, input irq_cfg_t c);
        irq_pin_t r;
        r.level = c.act_high ? asserted : ~asserted;
        r.oe    = c.open_drain ? asserted : 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/gpx_bank.sv
module gpx_bank
    import gpx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [W-1:0]     wdata,
    input  logic             clr,
    input  logic [W-1:0]     pin_in,
    output logic [W-1:0]     rd_val,
    output logic [W-1:0]     pin_out,
    output logic [W-1:0]     pin_oe,
    output logic [W-1:0]     pull_en,
    output logic [W-1:0]     flag,
    output logic [W-1:0]     capt
);

    logic [W-1:0] dir_q, inv_q, ien_q, ref_q, mode_q, pull_q, lat_q;
    logic [W-1:0] prev_q, hit, first;

    // control registers
    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '1;
            inv_q  <= '0;
            ien_q  <= '0;
            ref_q  <= '0;
            mode_q <= '0;
            pull_q <= '0;
            lat_q  <= '0;
        end else if (wr_en) begin
            case (reg_idx_e'(idx))
                IX_DIR:  dir_q  <= wdata;
                IX_INV:  inv_q  <= wdata;
                IX_IEN:  ien_q  <= wdata;
                IX_REF:  ref_q  <= wdata;
                IX_MODE: mode_q <= wdata;
                IX_PULL: pull_q <= wdata;
                IX_LAT:  lat_q  <= wdata;
                default: ;
            endcase
        end
    end

    // change / compare detection, lowest pin wins
    always_comb begin
        hit   = ien_q & dir_q & ((mode_q & (pin_in ^ ref_q)) | (~mode_q & (pin_in ^ prev_q)));
        first = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (hit[i]) begin
                first    = '0;
                first[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            flag   <= '0;
            capt   <= '0;
        end else begin
            prev_q <= pin_in;
            if (clr) begin
                flag <= '0;
            end else if (flag == '0 && hit != '0) begin
                flag <= first;
                capt <= pin_in ^ inv_q;
            end
        end
    end

    always_comb begin
        case (reg_idx_e'(idx))
            IX_DIR:  rd_val = dir_q;
            IX_INV:  rd_val = inv_q;
            IX_IEN:  rd_val = ien_q;
            IX_REF:  rd_val = ref_q;
            IX_MODE: rd_val = mode_q;
            IX_PULL: rd_val = pull_q;
            IX_FLAG: rd_val = flag;
            IX_CAPT: rd_val = capt;
            IX_PORT: rd_val = pin_in ^ inv_q;
            IX_LAT:  rd_val = lat_q;
            default: rd_val = '0;
        endcase
    end

    assign pin_out = lat_q;
    assign pin_oe  = ~dir_q;
    assign pull_en = pull_q;

endmodule

// File: rtl/gpx_irq_drive.sv
module gpx_irq_drive
    import gpx_pkg::*;
#(
    parameter int NBANK = 2
) (
    input  logic [NBANK-1:0] act,
    input  logic [7:0]       cfg,
    output logic [NBANK-1:0] irq_out,
    output logic [NBANK-1:0] irq_oe
);

    irq_cfg_t c;
    logic     any;

    assign c   = decode_cfg(cfg);
    assign any = |act;

    for (genvar b = 0; b < NBANK; b++) begin : g_out
        irq_pin_t p;
        assign p          = drive_irq(c.mirror ? any : act[b], c);
        assign irq_out[b] = p.level;
        assign irq_oe[b]  = p.oe;
    end

endmodule

// File: rtl/gpx_core.sv
module gpx_core
    import gpx_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int NBANK  = 2,
    localparam int SEL_W  = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int ADDR_W = IDX_W + SEL_W,
    localparam int PIN_W  = BANK_W * NBANK
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [BANK_W-1:0] reg_wdata,
    input  logic              reg_rd,
    output logic [BANK_W-1:0] reg_rdata,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe,
    output logic [PIN_W-1:0]  pull_en,
    output logic [NBANK-1:0]  irq_out,
    output logic [NBANK-1:0]  irq_oe
);

    logic [SEL_W-1:0]              sel;
    logic [IDX_W-1:0]              idx;
    logic [7:0]                    cfg_q;
    logic [BANK_W-1:0]             bank_rd [NBANK];
    logic [NBANK-1:0][BANK_W-1:0]  flag_all;
    logic [NBANK-1:0][BANK_W-1:0]  cap_all;
    logic [NBANK-1:0]              clr_all;
    logic [NBANK-1:0]              act;
    logic [BANK_W-1:0]             rd_pick;
    reg_idx_e                      clr_idx;

    assign sel = reg_addr[ADDR_W-1:IDX_W];
    assign idx = reg_addr[IDX_W-1:0];

    // shared configuration register
    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (reg_wr && reg_idx_e'(idx) == IX_CFG)
            cfg_q <= reg_wdata[7:0];
    end

    assign clr_idx = cfg_q[CFG_CLR_ON_CAP] ? IX_CAPT : IX_PORT;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic hit_sel;
        assign hit_sel    = (sel == SEL_W'(b));
        assign clr_all[b] = reg_rd && hit_sel && (reg_idx_e'(idx) == clr_idx);
        assign act[b]     = |flag_all[b];

        gpx_bank #(.W(BANK_W)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (reg_wr && hit_sel && reg_idx_e'(idx) != IX_CFG),
            .idx     (idx),
            .wdata   (reg_wdata),
            .clr     (clr_all[b]),
            .pin_in  (pin_in[b*BANK_W +: BANK_W]),
            .rd_val  (bank_rd[b]),
            .pin_out (pin_out[b*BANK_W +: BANK_W]),
            .pin_oe  (pin_oe[b*BANK_W +: BANK_W]),
            .pull_en (pull_en[b*BANK_W +: BANK_W]),
            .flag    (flag_all[b]),
            .capt    (cap_all[b])
        );
    end

    always_comb begin
        if (reg_idx_e'(idx) == IX_CFG)
            rd_pick = BANK_W'(cfg_q);
        else if (int'(sel) < NBANK)
            rd_pick = bank_rd[sel];
        else
            rd_pick = '0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            reg_rdata <= '0;
        else if (reg_rd)
            reg_rdata <= rd_pick;
    end

    gpx_irq_drive #(.NBANK(NBANK)) u_irq (
        .act     (act),
        .cfg     (cfg_q),
        .irq_out (irq_out),
        .irq_oe  (irq_oe)
    );

endmodule

// File: rtl/gpx_core_chk.sv
module gpx_core_chk #(
    parameter int BANK_W = 8,
    parameter int NBANK  = 2,
    parameter int PIN_W  = 16
) (
    input logic                      clk,
    input logic                      rst,
    input logic [PIN_W-1:0]          pin_oe,
    input logic [NBANK-1:0]          irq_out,
    input logic [NBANK-1:0]          irq_oe,
    input logic [7:0]                cfg_q,
    input logic [NBANK-1:0][BANK_W-1:0] flag_all,
    input logic [NBANK-1:0][BANK_W-1:0] cap_all,
    input logic [NBANK-1:0]          clr_all
);

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_oe == '0 && irq_out == '1 && irq_oe == '1));

    assert_mirror_R10: assert property (@(posedge clk) disable iff (rst)
        cfg_q[6] |-> ($countones(irq_out) == 0 || $countones(irq_out) == NBANK));

    for (genvar b = 0; b < NBANK; b++) begin : g_chk
        assert_single_flag_R7: assert property (@(posedge clk) disable iff (rst)
            $onehot0(flag_all[b]));

        assert_hold_pending_R8: assert property (@(posedge clk) disable iff (rst)
            (flag_all[b] != '0 && !clr_all[b]) |=> ($stable(flag_all[b]) && $stable(cap_all[b])));

        assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
            clr_all[b] |=> (flag_all[b] == '0));
    end

endmodule

bind gpx_core gpx_core_chk #(.BANK_W(BANK_W), .NBANK(NBANK), .PIN_W(PIN_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .pin_oe   (pin_oe),
    .irq_out  (irq_out),
    .irq_oe   (irq_oe),
    .cfg_q    (cfg_q),
    .flag_all (flag_all),
    .cap_all  (cap_all),
    .clr_all  (clr_all)
);

// File: tb/gpx_core_bench.sv
`timescale 1ns/1ps
module gpx_core_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe, pull_en;
    logic [1:0]  irq_out, irq_oe;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gpx_core u_gpx_core (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pull_en(pull_en),
        .irq_out(irq_out), .irq_oe(irq_oe)
    );

    // {write(1)/read-check(0), addr[4:0], data[7:0], expected[7:0]}
    localparam int NV = 22;
    localparam logic [21:0] VEC [NV] = '{
        {1'b1, 5'h00, 8'h0F, 8'h00}, {1'b0, 5'h00, 8'h00, 8'h0F},
        {1'b1, 5'h10, 8'hA5, 8'h00}, {1'b0, 5'h10, 8'h00, 8'hA5},
        {1'b0, 5'h00, 8'h00, 8'h0F}, {1'b1, 5'h06, 8'h3C, 8'h00},
        {1'b0, 5'h06, 8'h00, 8'h3C}, {1'b1, 5'h0A, 8'h55, 8'h00},
        {1'b0, 5'h0A, 8'h00, 8'h55}, {1'b0, 5'h1A, 8'h00, 8'h00},
        {1'b1, 5'h05, 8'h08, 8'h00}, {1'b0, 5'h15, 8'h00, 8'h08},
        {1'b1, 5'h15, 8'h00, 8'h00}, {1'b0, 5'h05, 8'h00, 8'h00},
        {1'b0, 5'h0B, 8'h00, 8'h00}, {1'b0, 5'h1F, 8'h00, 8'h00},
        {1'b1, 5'h07, 8'hFF, 8'h00}, {1'b0, 5'h07, 8'h00, 8'h00},
        {1'b1, 5'h08, 8'hFF, 8'h00}, {1'b0, 5'h08, 8'h00, 8'h00},
        {1'b1, 5'h09, 8'hFF, 8'h00}, {1'b0, 5'h0A, 8'h00, 8'h55}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(posedge clk);
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        check(tag, {8'h00, v}, {8'h00, exp});
    endtask

    task automatic pins(input logic [15:0] v);
        @(negedge clk);
        pin_in = v;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 pin_oe", pin_oe, 16'h0000);
        check("R1 pin_out", pin_out, 16'h0000);
        check("R1 pull_en", pull_en, 16'h0000);
        check("R1 irq", {12'h0, irq_oe, irq_out}, 16'h000F);
        rd_chk("R1 dir0", 5'h00, 8'hFF);
        rd_chk("R1 dir1", 5'h10, 8'hFF);
        rd_chk("R1 cfg", 5'h05, 8'h00);
        rd_chk("R1 lat1", 5'h1A, 8'h00);

        // R2 / R11 vector table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][21])
                wr(VEC[i][20:16], VEC[i][15:8]);
            else
                rd_chk($sformatf("R2/R11 vec%0d", i), VEC[i][20:16], VEC[i][7:0]);
        end

        // R3 pin drive
        check("R3 pin_oe", pin_oe, 16'h5AF0);
        check("R3 pin_out", pin_out[7:0], 16'h0055);
        check("R3 pull_en", pull_en, 16'h003C);

        wr(5'h00, 8'hFF);
        wr(5'h10, 8'hFF);

        // R4 inversion on port read
        wr(5'h01, 8'hF0);
        pins(16'h0033);
        rd_chk("R4 port0", 5'h09, 8'hC3);
        rd_chk("R4 port1", 5'h19, 8'h00);

        // R5 change mode, R8 capture and hold
        wr(5'h02, 8'hFF);
        pins(16'h0037);
        check("R5 irq low", {14'h0, irq_out}, 16'h0002);
        rd_chk("R5 flag", 5'h07, 8'h04);
        rd_chk("R8 capture", 5'h08, 8'hC7);
        pins(16'h0033);
        rd_chk("R8 flag held", 5'h07, 8'h04);
        rd_chk("R8 capture held", 5'h08, 8'hC7);
        rd_chk("R9 port read", 5'h09, 8'hC3);
        rd_chk("R9 cleared", 5'h07, 8'h00);

        // R7 lowest pin wins
        pins(16'h0030);
        rd_chk("R7 lowest", 5'h07, 8'h01);
        rd_chk("R9 clr", 5'h09, 8'hC0);

        // R7 two banks independent
        wr(5'h12, 8'hFF);
        pins(16'h8031);
        check("R7 both irq", {14'h0, irq_out}, 16'h0000);
        rd_chk("R7 flag1", 5'h17, 8'h80);
        rd_chk("R8 capture1", 5'h18, 8'h80);
        rd_chk("R8 capture0 other", 5'h08, 8'hC1);
        rd_chk("R9 clr1", 5'h19, 8'h80);
        check("R9 bank0 still", {14'h0, irq_out}, 16'h0002);
        rd_chk("R9 clr0", 5'h09, 8'hC1);
        check("R9 none", {14'h0, irq_out}, 16'h0003);

        // R9 clear on capture read
        wr(5'h05, 8'h01);
        pins(16'h8030);
        rd_chk("R9 port0", 5'h09, 8'hC0);
        rd_chk("R9 port no clear", 5'h07, 8'h01);
        rd_chk("R9 cap read", 5'h08, 8'hC0);
        rd_chk("R9 cap cleared", 5'h07, 8'h00);

        // R10 mirror, active high, open drain
        wr(5'h05, 8'h46);
        pins(16'h8031);
        check("R10 mirror od", {12'h0, irq_oe, irq_out}, 16'h000F);
        rd_chk("R10 clr", 5'h09, 8'hC1);
        check("R10 od idle", {12'h0, irq_oe, irq_out}, 16'h0000);
        wr(5'h05, 8'h02);
        pins(16'h8030);
        check("R10 act high single", {12'h0, irq_oe, irq_out}, 16'h000D);
        rd_chk("R10 clr2", 5'h09, 8'hC0);

        // R6 compare mode on bank 1 pin 8
        wr(5'h14, 8'h01);
        pins(16'h8130);
        rd_chk("R6 flag", 5'h17, 8'h01);
        rd_chk("R6 clr", 5'h19, 8'h81);
        rd_chk("R6 reflag", 5'h17, 8'h01);
        wr(5'h13, 8'h01);
        rd_chk("R6 clr2", 5'h19, 8'h81);
        rd_chk("R6 match quiet", 5'h17, 8'h00);

        // R5 output pins never flag
        wr(5'h00, 8'hFE);
        pins(16'h8131);
        pins(16'h8130);
        rd_chk("R5 output no flag", 5'h07, 8'h00);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule